// File: doc/BRIEF.md
# Four-Sensor Serial Thermometer Bridge

This block sits on a host register bus and lets software talk to four three-wire serial thermometers as if they were one device. Software toggles a clock level and a reset through a control register, pushes one command or data bit per write into a data-write register, and pulls one bit per read from a data-read register. Each read returns the same bit position from all four sensors at once: bit i of the returned byte belongs to sensor i.

The thermometers themselves are modelled inside the block. Each sensor has a temperature register and a configuration register, and both load reset values. An 8-bit command is shifted in least significant bit first. Three command codes are decoded. Start-convert clears the serial state. Read-temperature and read-config arm the block so that later reads walk through the selected register. Bits that arrive after a complete command build a separate data word, which is visible on an output port.

Top module: `therm_bridge`

## Requirements
- R1: After `rst_n` is released, `bus_rvalid` is 0, `unk_cmd` is 0 and `data_word` is 0.
- R2: Writing 0x01 to the control register (address 0) clears the command, the command bit count, the data word and the bit position. The clock-low flag and `unk_cmd` are kept.
- R3: Writing 0x02 to the control register sets the clock-low flag, and 0x03 clears it. A data-write (address 1) other than 0x80 is ignored while the flag is clear.
- R4: Command bits are taken least significant bit first. A data-write value of 0x01 makes the bit a one, and any other value except 0x80 makes it a zero.
- R5: When the eighth command bit completes the code 0xEE (start-convert), the whole serial state is cleared at once.
- R6: With read-temperature (0xAA) armed, a read of address 2 returns bit p of sensor i's 9-bit temperature register in `bus_rdata[i]`, where p is the current bit position, and then advances p. After the ninth read the serial state clears. Temperature registers reset to 44, which is 22 degrees in half-degree steps.
- R7: With read-config (0xAC) armed, reads behave as in R6 over the 8-bit config registers, and the serial state clears after the eighth read. Config registers reset to 0x02.
- R8: A data-write of 0x80 sets the bit position back to 0, whatever the state of the clock-low flag.
- R9: Once eight command bits are in, each further gated data-write sets bit p of `data_word` (to 1 for the value 0x01) and advances p.
- R10: A read of address 2 when no read command is armed returns 0 and sets `unk_cmd`. `unk_cmd` stays set until `rst_n` is asserted.
- R11: Reads of addresses 0, 1 and 3 return 0 and leave the bit position unchanged. Writes to addresses 2 and 3 have no effect.
- R12: `bus_rvalid` rises exactly one cycle after `bus_rd` and carries that read's data. When `bus_rd` and `bus_wr` are high together, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 data-write, 2 data-read |
| bus_wdata | input | 8 | Write value |
| bus_rdata | output | 8 | Read value, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| unk_cmd | output | 1 | Sticky flag: a read was made with no read command armed |
| data_word | output | DWORD_W | Data bits collected after a complete command |

## Verification
Most faults in this block show up in the read stream. A command bit placed in the wrong position, or a missed clock gate, leaves the command unarmed, so the very next data read returns zero and `unk_cmd` rises. A bit position that is off by one makes the sampled bytes shift against the expected per-sensor bit columns within one or two reads. The four sensors are loaded with different values so that any swapped lane shows on the first read where their bits differ. A clear that arrives late or never is caught at the read that should start a new sequence: it returns a stale bit or zero.

// File: rtl/therm_pkg.sv
package therm_pkg;

  localparam int BUS_W = 8;

  // register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_WDAT = 2'd1;
  localparam logic [1:0] A_RDAT = 2'd2;

  // control register values
  localparam logic [BUS_W-1:0] CTRL_SER_RESET = 8'h01;
  localparam logic [BUS_W-1:0] CTRL_CLK_LO    = 8'h02;
  localparam logic [BUS_W-1:0] CTRL_CLK_HI    = 8'h03;

  // data-write register values
  localparam logic [BUS_W-1:0] DW_HIGH      = 8'h01;
  localparam logic [BUS_W-1:0] DW_ENABLE_RD = 8'h80;

  // command codes
  localparam logic [7:0] CMD_RD_TEMP = 8'hAA;
  localparam logic [7:0] CMD_RD_CFG  = 8'hAC;
  localparam logic [7:0] CMD_CONVERT = 8'hEE;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_TEMP = 2'd1,
    ARM_CFG  = 2'd2
  } arm_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // the bit position is the last one of a sequence of length len
  function automatic logic is_last_pos(input int pos, input int len);
    return (pos + 1) >= len;
  endfunction

endpackage

// File: rtl/therm_ctrl_port.sv
module therm_ctrl_port
  import therm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [BUS_W-1:0] ctrl_val,
  output logic             clk_low_q,
  output logic             clear_req
);

  assign clear_req = ctrl_we && (ctrl_val == CTRL_SER_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_low_q <= 1'b0;
    end else if (ctrl_we) begin
      if (ctrl_val == CTRL_CLK_LO)      clk_low_q <= 1'b1;
      else if (ctrl_val == CTRL_CLK_HI) clk_low_q <= 1'b0;
    end
  end

endmodule

// File: rtl/therm_serial_engine.sv
module therm_serial_engine
  import therm_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int DWORD_W = 16,
  parameter int TEMP_W  = 9,
  parameter int CFG_W   = 8,
  parameter int POS_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_clear,
  input  logic               dw_we,
  input  logic [BUS_W-1:0]   dw_val,
  input  logic               clk_low,
  input  logic               rd_strobe,
  output arm_e               arm,
  output logic [POS_W-1:0]   bit_pos,
  output logic [DWORD_W-1:0] word_q,
  output logic               clear_all,
  output logic               rd_bad
);

  localparam int CPOS_W = $clog2(CMD_W + 1);

  logic [CMD_W-1:0]  cmd_q;
  logic [CMD_W-1:0]  cmd_nxt;
  logic [CPOS_W-1:0] cpos_q;
  logic [POS_W-1:0]  pos_q;

  logic is_enable, is_high, shift_go, cmd_done;
  logic cmd_step, data_step, conv_hit;
  logic rd_ok, rd_last;
  int   rd_len;

  assign is_enable = (dw_val == DW_ENABLE_RD);
  assign is_high   = (dw_val == DW_HIGH);
  assign cmd_done  = (cpos_q == CPOS_W'(CMD_W));
  assign shift_go  = dw_we && !is_enable && clk_low;
  assign cmd_step  = shift_go && !cmd_done;
  assign data_step = shift_go && cmd_done;

  // command word with the incoming bit placed at the current position
  assign cmd_nxt = cmd_q | (CMD_W'(is_high) << cpos_q);

  assign conv_hit = cmd_step && (cpos_q == CPOS_W'(CMD_W - 1))
                    && (cmd_nxt == CMD_W'(CMD_CONVERT));

  always_comb begin
    arm = ARM_NONE;
    if (cmd_done) begin
      if (cmd_q == CMD_W'(CMD_RD_TEMP))     arm = ARM_TEMP;
      else if (cmd_q == CMD_W'(CMD_RD_CFG)) arm = ARM_CFG;
    end
  end

  always_comb begin
    rd_len = (arm == ARM_TEMP) ? TEMP_W : CFG_W;
  end

  assign rd_ok     = rd_strobe && (arm != ARM_NONE);
  assign rd_bad    = rd_strobe && (arm == ARM_NONE);
  assign rd_last   = rd_ok && is_last_pos(int'(pos_q), rd_len);
  assign clear_all = ctrl_clear || conv_hit || rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      cmd_q  <= '0;
      cpos_q <= '0;
      pos_q  <= '0;
      word_q <= '0;
    end else begin
      if (cmd_step) begin
        cmd_q  <= cmd_nxt;
        cpos_q <= cpos_q + 1'b1;
      end
      if (dw_we && is_enable) begin
        pos_q <= '0;
      end
      if (data_step && (int'(pos_q) < DWORD_W)) begin
        word_q <= word_q | (DWORD_W'(is_high) << pos_q);
        pos_q  <= pos_q + 1'b1;
      end
      if (rd_ok) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign bit_pos = pos_q;

endmodule

// File: rtl/therm_sensor_bank.sv
module therm_sensor_bank
  import therm_pkg::*;
#(
  parameter int                        NUM_SENSORS = 4,
  parameter int                        TEMP_W      = 9,
  parameter int                        CFG_W       = 8,
  parameter int                        POS_W       = 5,
  parameter logic [NUM_SENSORS*TEMP_W-1:0] TEMP_INIT = {NUM_SENSORS{9'd44}},
  parameter logic [NUM_SENSORS*CFG_W-1:0]  CFG_INIT  = {NUM_SENSORS{8'h02}}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  arm_e                   arm,
  input  logic [POS_W-1:0]       bit_pos,
  output logic [NUM_SENSORS-1:0] lane_bits
);

  logic in_temp, in_cfg;
  assign in_temp = (arm == ARM_TEMP) && (int'(bit_pos) < TEMP_W);
  assign in_cfg  = (arm == ARM_CFG)  && (int'(bit_pos) < CFG_W);

  for (genvar i = 0; i < NUM_SENSORS; i++) begin : g_sensor
    logic [TEMP_W-1:0] temp_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [TEMP_W-1:0] temp_sh;
    logic [CFG_W-1:0]  cfg_sh;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        temp_q <= TEMP_INIT[i*TEMP_W +: TEMP_W];
        cfg_q  <= CFG_INIT[i*CFG_W +: CFG_W];
      end else begin
        temp_q <= temp_q;
        cfg_q  <= cfg_q;
      end
    end

    assign temp_sh      = temp_q >> bit_pos;
    assign cfg_sh       = cfg_q >> bit_pos;
    assign lane_bits[i] = in_temp ? temp_sh[0] : (in_cfg ? cfg_sh[0] : 1'b0);
  end

endmodule

// File: rtl/therm_bridge.sv
module therm_bridge
  import therm_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int CMD_W       = 8,
  parameter int TEMP_W      = 9,
  parameter int CFG_W       = 8,
  parameter int DWORD_W     = 16,
  parameter logic [NUM_SENSORS*TEMP_W-1:0] TEMP_INIT = {NUM_SENSORS{9'd44}},
  parameter logic [NUM_SENSORS*CFG_W-1:0]  CFG_INIT  = {NUM_SENSORS{8'h02}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  output logic               unk_cmd,
  output logic [DWORD_W-1:0] data_word
);

  localparam int POS_W = $clog2(max3(DWORD_W, TEMP_W, CFG_W) + 1);

  // named internal events
  logic acc_wr, ctrl_we, dw_we, rd_strobe;
  logic clk_low_q, clear_req, ser_clear, rd_bad;
  arm_e arm;
  logic [POS_W-1:0]       bit_pos;
  logic [NUM_SENSORS-1:0] lane_bits;
  logic [BUS_W-1:0]       rd_word;

  assign acc_wr    = bus_wr && !bus_rd;
  assign ctrl_we   = acc_wr && (bus_addr == A_CTRL);
  assign dw_we     = acc_wr && (bus_addr == A_WDAT);
  assign rd_strobe = bus_rd && (bus_addr == A_RDAT);

  therm_ctrl_port u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ctrl_val  (bus_wdata),
    .clk_low_q (clk_low_q),
    .clear_req (clear_req)
  );

  therm_serial_engine #(
    .CMD_W   (CMD_W),
    .DWORD_W (DWORD_W),
    .TEMP_W  (TEMP_W),
    .CFG_W   (CFG_W),
    .POS_W   (POS_W)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_clear (clear_req),
    .dw_we      (dw_we),
    .dw_val     (bus_wdata),
    .clk_low    (clk_low_q),
    .rd_strobe  (rd_strobe),
    .arm        (arm),
    .bit_pos    (bit_pos),
    .word_q     (data_word),
    .clear_all  (ser_clear),
    .rd_bad     (rd_bad)
  );

  therm_sensor_bank #(
    .NUM_SENSORS (NUM_SENSORS),
    .TEMP_W      (TEMP_W),
    .CFG_W       (CFG_W),
    .POS_W       (POS_W),
    .TEMP_INIT   (TEMP_INIT),
    .CFG_INIT    (CFG_INIT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .bit_pos   (bit_pos),
    .lane_bits (lane_bits)
  );

  always_comb begin
    rd_word = '0;
    rd_word[NUM_SENSORS-1:0] = lane_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      unk_cmd    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= rd_strobe ? rd_word : '0;
      if (rd_bad) unk_cmd <= 1'b1;
    end
  end

endmodule

// File: rtl/therm_bridge_chk.sv
module therm_bridge_chk
  import therm_pkg::*;
#(
  parameter int DWORD_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [1:0]         bus_addr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               bus_rvalid,
  input logic               unk_cmd,
  input logic [DWORD_W-1:0] data_word,
  input logic               clk_low_q,
  input logic               ser_clear
);

  a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r12_rvalid_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unk_cmd |=> unk_cmd);

  a_r11_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != A_RDAT) |=> (bus_rdata == '0));

  a_r2_clear_empties_word: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clear |=> (data_word == '0));

  a_r3_gated_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == A_WDAT && !clk_low_q && bus_wdata != DW_ENABLE_RD)
    |=> $stable(data_word));

  a_r3_clk_low_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == A_CTRL && bus_wdata == CTRL_CLK_LO) |=> clk_low_q);

  a_r9_word_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && !bus_rd && bus_addr == A_WDAT) && !ser_clear) |=> $stable(data_word));

endmodule

bind therm_bridge therm_bridge_chk #(.DWORD_W(DWORD_W)) u_chk (.*);

// File: tb/therm_bridge_tb.sv
module therm_bridge_tb;

  localparam int NS = 4;
  localparam int TW = 9;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam logic [NS*TW-1:0] T_INIT = {9'h0FF, 9'h1EC, 9'd50, 9'd44};
  localparam logic [NS*CW-1:0] C_INIT = {8'hC1, 8'h5A, 8'h83, 8'h02};
  localparam int T_V [NS] = '{44, 50, 492, 255};
  localparam int C_V [NS] = '{2, 131, 90, 193};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [7:0]    bus_wdata = 8'd0;
  logic [7:0]    bus_rdata;
  logic          bus_rvalid;
  logic          unk_cmd;
  logic [DW-1:0] data_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  therm_bridge #(
    .NUM_SENSORS (NS),
    .TEMP_W      (TW),
    .CFG_W       (CW),
    .DWORD_W     (DW),
    .TEMP_INIT   (T_INIT),
    .CFG_INIT    (C_INIT)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .unk_cmd    (unk_cmd),
    .data_word  (data_word)
  );

  // expected byte: bit i is bit pos of sensor i's selected register
  function automatic logic [7:0] lanes(input bit cfg, input int pos);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < NS; i++) begin
      int v;
      int w;
      v = cfg ? C_V[i] : T_V[i];
      w = cfg ? CW : TW;
      if (pos < w) r[i] = 1'((v >> pos) & 1);
    end
    return r;
  endfunction

  task automatic check_val(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R12 actual=unexpected rvalid expected=no read data");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_val(int'(bus_rdata), int'(e), t);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic shift_cmd(input logic [7:0] code, input logic [7:0] lowval);
    for (int b = 0; b < 8; b++) wr(2'd1, code[b] ? 8'h01 : lowval);
  endtask

  task automatic read_seq(input bit cfg, input int first, input int last, input string tag);
    for (int p = first; p <= last; p++) rd(2'd2, lanes(cfg, p), tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check_val(int'(bus_rvalid), 0, "R1 rvalid");
    check_val(int'(unk_cmd), 0, "R1 unk_cmd");
    check_val(int'(data_word), 0, "R1 data_word");

    // R11 other-address read is zero and harmless
    rd(2'd0, 8'h00, "R11 ctrl read");
    check_val(int'(unk_cmd), 0, "R11 no flag");

    // R3 gated writes while clock high are dropped
    wr(2'd0, 8'h03);
    for (int k = 0; k < 8; k++) wr(2'd1, 8'h01);
    check_val(int'(data_word), 0, "R3 gated word");
    wr(2'd0, 8'h02);
    shift_cmd(8'hAA, 8'h00);
    read_seq(1'b0, 0, 8, "R6 temp read");
    check_val(int'(unk_cmd), 0, "R6 no flag");
    // R10 read after sequence end: nothing armed
    rd(2'd2, 8'h00, "R10 unarmed read");
    check_val(int'(unk_cmd), 1, "R10 flag set");

    // R2 clear mid-command, R4 alternate low value
    for (int k = 0; k < 4; k++) wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    shift_cmd(8'hAC, 8'h42);
    read_seq(1'b1, 0, 7, "R7 cfg read");
    rd(2'd2, 8'h00, "R7 cleared after eight");

    // R5 start-convert clears; a following read command works
    shift_cmd(8'hEE, 8'h00);
    shift_cmd(8'hAA, 8'h00);
    read_seq(1'b0, 0, 8, "R5 after convert");

    // R8 enable-read restarts position, even with clock high
    shift_cmd(8'hAA, 8'h00);
    read_seq(1'b0, 0, 2, "R8 first part");
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h02);
    read_seq(1'b0, 0, 8, "R8 restart");

    // R9 data word after complete command
    shift_cmd(8'hAA, 8'h00);
    wr(2'd1, 8'h01); wr(2'd1, 8'h00); wr(2'd1, 8'h01); wr(2'd1, 8'h01);
    check_val(int'(data_word), 13, "R9 data word");
    wr(2'd0, 8'h01);
    check_val(int'(data_word), 0, "R2 word cleared");

    // R11 writes to read register ignored, reads elsewhere keep position
    shift_cmd(8'hAA, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h80);
    read_seq(1'b0, 0, 1, "R11 read start");
    rd(2'd1, 8'h00, "R11 addr1 read");
    rd(2'd3, 8'h00, "R11 addr3 read");
    read_seq(1'b0, 2, 4, "R11 position kept");

    // R12 read and write together: write dropped
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h80;
    exp_q.push_back(8'h00);
    tag_q.push_back("R12 joint access");
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    read_seq(1'b0, 5, 8, "R12 write dropped");

    // R10 flag survives control reset, cleared by rst_n
    wr(2'd0, 8'h01);
    check_val(int'(unk_cmd), 1, "R10 sticky");
    do_reset();
    check_val(int'(unk_cmd), 0, "R10 cleared by reset");

    repeat (3) @(negedge clk);
    check_val(exp_q.size(), 0, "R12 all reads answered");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule